// File: doc/BRIEF.md
# Two-Region Memory Attribute Unit

This block assigns memory attributes to every processor reference. It holds two region descriptors. Each descriptor names an address region by an 8-bit base and an 8-bit mask over the top byte of the address. It also carries a privilege filter, an enable, and the attributes that apply inside the region: a 2-bit cache mode, a buffered-write enable and a write-protect flag. References into the on-chip flash or SRAM windows skip the descriptors altogether. All other references are tested against both enabled descriptors. When neither descriptor matches, the reference takes the default cache mode and buffered-write enable that the cache control logic supplies on dedicated inputs.

Software loads a descriptor through a control-register write port that is keyed by a 12-bit register code. Only supervisor-mode writes take effect. A user-mode attempt is dropped and raises a privilege-violation pulse. The descriptors cannot be read through the normal path; a separate debug read port returns them. Every request gets a registered response one cycle later. The response carries the effective attributes, which descriptor supplied them, a protection-fault flag, and whether a write may be forwarded.

Top module: `region_attr_unit`

## Requirements
- R1: After a synchronous reset, both descriptors are disabled and read back as zero, and every non-bypass reference takes the default attributes.
- R2: A write with `cr_super`=1 and code 0x004 loads descriptor 0, and code 0x005 loads descriptor 1. Field layout: base [31:24], mask [23:16], enable [15], privilege filter [14:13], cache mode [6:5], buffered-write [4], write-protect [2]. All other bits are stored as zero. Writes with any other code change nothing.
- R3: A write with code 0x004 or 0x005 and `cr_super`=0 leaves both descriptors unchanged and sets `priv_fault` for exactly the following cycle.
- R4: A debug read of code 0x004 or 0x005 returns that descriptor on `dbg_rdata` one cycle later. Any other code returns zero.
- R5: Addresses in the flash window 0xF000_0000–0xF007_FFFF or the SRAM window 0x2000_0000–0x2000_FFFF give `rsp_bypass`=1, region 0, all attributes zero, no fault, and forwarding of writes.
- R6: A descriptor matches when address bits [31:24] equal its base in every bit position where its mask bit is 0. Mask bits set to 1 are don't-care.
- R7: The privilege filter admits only user references when it is 00, only supervisor references when it is 01, and both when it is 1x. A disabled descriptor never matches.
- R8: `rsp_region` is one-hot, with bit 0 for descriptor 0 and bit 1 for descriptor 1. When both descriptors match, descriptor 0 wins.
- R9: When no descriptor matches a non-bypass reference, `rsp_cmode` and `rsp_bwe` take `dflt_cmode` and `dflt_bwe`, and `rsp_region` and `rsp_wp` are zero.
- R10: A write that hits a descriptor with write-protect set gives `rsp_fault`=1 and `rsp_wr_fwd`=0. Reads never fault, and any other write gives `rsp_wr_fwd`=1.
- R11: The response appears in the cycle after `req_valid`. When there was no request, every response output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_code | input | 12 | Register code of the write |
| cr_wdata | input | 32 | Write data |
| cr_super | input | 1 | Writer is in supervisor mode |
| dbg_rd_en | input | 1 | Debug read strobe |
| dbg_code | input | 12 | Register code of the debug read |
| dbg_rdata | output | 32 | Debug read data, registered |
| req_valid | input | 1 | Reference request valid |
| req_addr | input | 32 | Reference address |
| req_write | input | 1 | Reference is a write |
| req_super | input | 1 | Reference is in supervisor mode |
| dflt_cmode | input | 2 | Default cache mode |
| dflt_bwe | input | 1 | Default buffered-write enable |
| rsp_valid | output | 1 | Response valid |
| rsp_bypass | output | 1 | Reference hit the flash or SRAM window |
| rsp_region | output | 2 | One-hot matching descriptor |
| rsp_cmode | output | 2 | Effective cache mode |
| rsp_bwe | output | 1 | Effective buffered-write enable |
| rsp_wp | output | 1 | Effective write protect |
| rsp_fault | output | 1 | Protected write detected |
| rsp_wr_fwd | output | 1 | Write may be forwarded |
| priv_fault | output | 1 | User-mode descriptor write was rejected |

## Verification
The assertions assume that `rst` is held high from time zero until the first clock edges have passed. They also assume the request and write inputs are stable around each rising edge. The bench meets both by asserting reset at time zero and driving every input on the falling edge. The property on the privilege pulse assumes that a rejected write is a single-cycle event. The stimulus never depends on that event repeating, and the reference model predicts the pulse cycle by cycle for both directed and random writes.

// File: rtl/rau_pkg.sv
package rau_pkg;
  localparam int REG_W = 32;
  localparam logic [REG_W-1:0] KEEP_BITS = 32'hFFFF_E074;

  typedef struct packed {
    logic [7:0] base;
    logic [7:0] mask;
    logic       en;
    logic [1:0] smode;
    logic [1:0] cmode;
    logic       bwe;
    logic       wp;
  } region_t;

  function automatic region_t to_region(logic [REG_W-1:0] w);
    region_t r;
    r.base  = w[31:24];
    r.mask  = w[23:16];
    r.en    = w[15];
    r.smode = w[14:13];
    r.cmode = w[6:5];
    r.bwe   = w[4];
    r.wp    = w[2];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] from_region(region_t r);
    logic [REG_W-1:0] w;
    w        = '0;
    w[31:24] = r.base;
    w[23:16] = r.mask;
    w[15]    = r.en;
    w[14:13] = r.smode;
    w[6:5]   = r.cmode;
    w[4]     = r.bwe;
    w[2]     = r.wp;
    return w;
  endfunction
endpackage

// File: rtl/rau_regfile.sv
module rau_regfile
  import rau_pkg::*;
#(
  parameter int NREG = 2,
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] CODE_BASE = 12'h004
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [CODE_W-1:0]      wr_code,
  input  logic [REG_W-1:0]       wr_data,
  input  logic                   wr_super,
  input  logic                   dbg_en,
  input  logic [CODE_W-1:0]      dbg_code,
  output region_t [NREG-1:0]     regs_o,
  output logic                   priv_fault_o,
  output logic [REG_W-1:0]       dbg_rdata_o
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [CODE_W-1:0] NREG_C = CODE_W'(NREG);

  logic [CODE_W-1:0] wr_off, dbg_off;
  logic wr_hit, dbg_hit;
  region_t [NREG-1:0] regs_q;

  assign wr_off  = wr_code - CODE_BASE;
  assign dbg_off = dbg_code - CODE_BASE;
  assign wr_hit  = wr_en && (wr_off < NREG_C);
  assign dbg_hit = dbg_en && (dbg_off < NREG_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
    end else if (wr_hit && wr_super) begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_off == CODE_W'(i)) regs_q[i] <= to_region(wr_data);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) priv_fault_o <= 1'b0;
    else     priv_fault_o <= wr_hit && !wr_super;
  end

  always_ff @(posedge clk) begin
    if (rst || !dbg_hit) dbg_rdata_o <= '0;
    else                 dbg_rdata_o <= from_region(regs_q[dbg_off[IDX_W-1:0]]);
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/rau_region_match.sv
module rau_region_match
  import rau_pkg::*;
(
  input  region_t    cfg,
  input  logic [7:0] addr_hi,
  input  logic       req_super,
  output logic       hit
);
  logic addr_ok, mode_ok;

  assign addr_ok = (((addr_hi ^ cfg.base) & ~cfg.mask) == 8'h00);
  assign mode_ok = cfg.smode[1] || (cfg.smode[0] == req_super);
  assign hit     = cfg.en && addr_ok && mode_ok;
endmodule

// File: rtl/rau_select.sv
module rau_select
  import rau_pkg::*;
#(
  parameter int NREG = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               bypass,
  input  logic [NREG-1:0]    hits,
  input  region_t [NREG-1:0] regs,
  input  logic [1:0]         dflt_cmode,
  input  logic               dflt_bwe,
  output logic               rsp_valid,
  output logic               rsp_bypass,
  output logic [NREG-1:0]    rsp_region,
  output logic [1:0]         rsp_cmode,
  output logic               rsp_bwe,
  output logic               rsp_wp,
  output logic               rsp_fault,
  output logic               rsp_wr_fwd
);
  logic [NREG-1:0] sel;
  logic [1:0]      cmode;
  logic            bwe, wp, fault;

  always_comb begin
    sel   = '0;
    cmode = dflt_cmode;
    bwe   = dflt_bwe;
    wp    = 1'b0;
    if (bypass) begin
      cmode = 2'b00;
      bwe   = 1'b0;
    end else begin
      for (int i = NREG - 1; i >= 0; i--) begin
        if (hits[i]) begin
          sel    = '0;
          sel[i] = 1'b1;
          cmode  = regs[i].cmode;
          bwe    = regs[i].bwe;
          wp     = regs[i].wp;
        end
      end
    end
  end

  assign fault = req_write && wp;

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid  <= 1'b0;
      rsp_bypass <= 1'b0;
      rsp_region <= '0;
      rsp_cmode  <= 2'b00;
      rsp_bwe    <= 1'b0;
      rsp_wp     <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_wr_fwd <= 1'b0;
    end else begin
      rsp_valid  <= 1'b1;
      rsp_bypass <= bypass;
      rsp_region <= sel;
      rsp_cmode  <= cmode;
      rsp_bwe    <= bwe;
      rsp_wp     <= wp;
      rsp_fault  <= fault;
      rsp_wr_fwd <= req_write && !fault;
    end
  end
endmodule

// File: rtl/region_attr_unit.sv
module region_attr_unit
  import rau_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG = 2,
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] CODE_BASE = 12'h004,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 32'hF000_0000,
  parameter int FLASH_AW = 19,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 32'h2000_0000,
  parameter int SRAM_AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cr_wr_en,
  input  logic [CODE_W-1:0] cr_code,
  input  logic [REG_W-1:0]  cr_wdata,
  input  logic              cr_super,
  input  logic              dbg_rd_en,
  input  logic [CODE_W-1:0] dbg_code,
  output logic [REG_W-1:0]  dbg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_super,
  input  logic [1:0]        dflt_cmode,
  input  logic              dflt_bwe,
  output logic              rsp_valid,
  output logic              rsp_bypass,
  output logic [NREG-1:0]   rsp_region,
  output logic [1:0]        rsp_cmode,
  output logic              rsp_bwe,
  output logic              rsp_wp,
  output logic              rsp_fault,
  output logic              rsp_wr_fwd,
  output logic              priv_fault
);
  localparam logic [ADDR_W-1:0] FLASH_MASK = ~((ADDR_W'(1) << FLASH_AW) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] SRAM_MASK  = ~((ADDR_W'(1) << SRAM_AW) - ADDR_W'(1));

  region_t [NREG-1:0] regs;
  logic [NREG-1:0]    hits;
  logic               in_flash, in_sram, bypass;

  rau_regfile #(.NREG(NREG), .CODE_W(CODE_W), .CODE_BASE(CODE_BASE)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cr_wr_en), .wr_code(cr_code), .wr_data(cr_wdata), .wr_super(cr_super),
    .dbg_en(dbg_rd_en), .dbg_code(dbg_code),
    .regs_o(regs), .priv_fault_o(priv_fault), .dbg_rdata_o(dbg_rdata)
  );

  assign in_flash = (((req_addr ^ FLASH_BASE) & FLASH_MASK) == '0);
  assign in_sram  = (((req_addr ^ SRAM_BASE) & SRAM_MASK) == '0);
  assign bypass   = in_flash || in_sram;

  for (genvar g = 0; g < NREG; g++) begin : g_match
    rau_region_match u_match (
      .cfg(regs[g]),
      .addr_hi(req_addr[ADDR_W-1 -: 8]),
      .req_super(req_super),
      .hit(hits[g])
    );
  end

  rau_select #(.NREG(NREG)) u_sel (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .bypass(bypass), .hits(hits), .regs(regs),
    .dflt_cmode(dflt_cmode), .dflt_bwe(dflt_bwe),
    .rsp_valid(rsp_valid), .rsp_bypass(rsp_bypass), .rsp_region(rsp_region),
    .rsp_cmode(rsp_cmode), .rsp_bwe(rsp_bwe), .rsp_wp(rsp_wp),
    .rsp_fault(rsp_fault), .rsp_wr_fwd(rsp_wr_fwd)
  );
endmodule

// File: rtl/region_attr_unit_chk.sv
module region_attr_unit_chk #(
  parameter int NREG = 2,
  parameter int CODE_W = 12,
  parameter logic [CODE_W-1:0] CODE_BASE = 12'h004
) (
  input logic              clk,
  input logic              rst,
  input logic              cr_wr_en,
  input logic [CODE_W-1:0] cr_code,
  input logic              cr_super,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_bypass,
  input logic [NREG-1:0]   rsp_region,
  input logic [1:0]        rsp_cmode,
  input logic              rsp_wp,
  input logic              rsp_fault,
  input logic              rsp_wr_fwd,
  input logic              priv_fault
);
  logic [CODE_W-1:0] off;
  logic code_hit;
  assign off      = cr_code - CODE_BASE;
  assign code_hit = cr_wr_en && (off < CODE_W'(NREG));

  assert_resp_follows_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && rsp_region == '0 && !rsp_fault && !rsp_wr_fwd));
  assert_region_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_region));
  assert_bypass_clean_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_bypass |-> (rsp_region == '0 && !rsp_fault && rsp_cmode == 2'b00));
  assert_fault_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (!rsp_wr_fwd && rsp_wp && rsp_region != '0));
  assert_default_no_wp_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_bypass && rsp_region == '0) |-> (!rsp_wp && !rsp_fault));
  assert_user_write_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (code_hit && !cr_super) |=> priv_fault);
  assert_super_write_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !(code_hit && !cr_super) |=> !priv_fault);
endmodule

bind region_attr_unit region_attr_unit_chk #(
  .NREG(NREG), .CODE_W(CODE_W), .CODE_BASE(CODE_BASE)
) u_chk (
  .clk(clk), .rst(rst), .cr_wr_en(cr_wr_en), .cr_code(cr_code), .cr_super(cr_super),
  .req_valid(req_valid), .rsp_valid(rsp_valid), .rsp_bypass(rsp_bypass),
  .rsp_region(rsp_region), .rsp_cmode(rsp_cmode), .rsp_wp(rsp_wp),
  .rsp_fault(rsp_fault), .rsp_wr_fwd(rsp_wr_fwd), .priv_fault(priv_fault)
);

// File: tb/region_attr_unit_test.sv
module region_attr_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cr_wr_en = 0, cr_super = 0, dbg_rd_en = 0;
  logic [11:0] cr_code = '0, dbg_code = '0;
  logic [31:0] cr_wdata = '0, req_addr = '0;
  logic req_valid = 0, req_write = 0, req_super = 0, dflt_bwe = 0;
  logic [1:0] dflt_cmode = '0;
  logic [31:0] dbg_rdata;
  logic rsp_valid, rsp_bypass, rsp_bwe, rsp_wp, rsp_fault, rsp_wr_fwd, priv_fault;
  logic [1:0] rsp_region, rsp_cmode;

  int checks = 0, failures = 0;
  bit done = 0;
  string scen = "R1";

  // reference model state and expected outputs
  logic [31:0] m_reg [2];
  logic [31:0] e_dbg;
  logic e_valid, e_bypass, e_bwe, e_wp, e_fault, e_fwd, e_priv;
  logic [1:0] e_region, e_cmode;

  always #10 clk = ~clk;

  region_attr_unit uut (
    .clk(clk), .rst(rst), .cr_wr_en(cr_wr_en), .cr_code(cr_code), .cr_wdata(cr_wdata),
    .cr_super(cr_super), .dbg_rd_en(dbg_rd_en), .dbg_code(dbg_code), .dbg_rdata(dbg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_super(req_super),
    .dflt_cmode(dflt_cmode), .dflt_bwe(dflt_bwe), .rsp_valid(rsp_valid),
    .rsp_bypass(rsp_bypass), .rsp_region(rsp_region), .rsp_cmode(rsp_cmode),
    .rsp_bwe(rsp_bwe), .rsp_wp(rsp_wp), .rsp_fault(rsp_fault), .rsp_wr_fwd(rsp_wr_fwd),
    .priv_fault(priv_fault)
  );

  function automatic bit region_hits(logic [31:0] r, logic [31:0] a, logic sup);
    if (!r[15]) return 0;
    for (int b = 0; b < 8; b++)
      if (!r[16 + b] && (a[24 + b] != r[24 + b])) return 0;
    case (r[14:13])
      2'b00:   return !sup;
      2'b01:   return sup;
      default: return 1;
    endcase
  endfunction

  task automatic chk(string fld, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL [%s] %s actual=%h expected=%h at %0t", scen, fld, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int hit_idx;
    bit byp;
    if (rst) begin
      m_reg[0] = '0; m_reg[1] = '0;
      e_dbg = '0; e_priv = 0;
      {e_valid, e_bypass, e_bwe, e_wp, e_fault, e_fwd} = '0;
      e_region = '0; e_cmode = '0;
      return;
    end
    e_priv = cr_wr_en && !cr_super && (cr_code == 12'h004 || cr_code == 12'h005);
    if (dbg_rd_en && dbg_code == 12'h004)      e_dbg = m_reg[0];
    else if (dbg_rd_en && dbg_code == 12'h005) e_dbg = m_reg[1];
    else                                       e_dbg = '0;
    {e_valid, e_bypass, e_bwe, e_wp, e_fault, e_fwd} = '0;
    e_region = '0; e_cmode = '0;
    if (req_valid) begin
      e_valid = 1;
      byp = (req_addr >= 32'hF000_0000 && req_addr <= 32'hF007_FFFF) ||
            (req_addr >= 32'h2000_0000 && req_addr <= 32'h2000_FFFF);
      if (byp) begin
        e_bypass = 1;
        e_fwd = req_write;
      end else begin
        hit_idx = -1;
        for (int k = 0; k < 2; k++)
          if (hit_idx < 0 && region_hits(m_reg[k], req_addr, req_super)) hit_idx = k;
        if (hit_idx < 0) begin
          e_cmode = dflt_cmode; e_bwe = dflt_bwe;
          e_fwd = req_write;
        end else begin
          e_region = (hit_idx == 0) ? 2'b01 : 2'b10;
          e_cmode = m_reg[hit_idx][6:5];
          e_bwe = m_reg[hit_idx][4];
          e_wp = m_reg[hit_idx][2];
          e_fault = req_write && e_wp;
          e_fwd = req_write && !e_fault;
        end
      end
    end
    if (cr_wr_en && cr_super && cr_code == 12'h004) m_reg[0] = cr_wdata & 32'hFFFF_E074;
    if (cr_wr_en && cr_super && cr_code == 12'h005) m_reg[1] = cr_wdata & 32'hFFFF_E074;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("rsp_valid(R11)", 32'(rsp_valid), 32'(e_valid));
    chk("rsp_bypass(R5)", 32'(rsp_bypass), 32'(e_bypass));
    chk("rsp_region(R8)", 32'(rsp_region), 32'(e_region));
    chk("rsp_cmode(R9)", 32'(rsp_cmode), 32'(e_cmode));
    chk("rsp_bwe(R9)", 32'(rsp_bwe), 32'(e_bwe));
    chk("rsp_wp(R10)", 32'(rsp_wp), 32'(e_wp));
    chk("rsp_fault(R10)", 32'(rsp_fault), 32'(e_fault));
    chk("rsp_wr_fwd(R10)", 32'(rsp_wr_fwd), 32'(e_fwd));
    chk("priv_fault(R3)", 32'(priv_fault), 32'(e_priv));
    chk("dbg_rdata(R4)", dbg_rdata, e_dbg);
  endtask

  task automatic idle();
    cr_wr_en = 0; dbg_rd_en = 0; req_valid = 0; req_write = 0;
  endtask

  task automatic wr(logic [11:0] code, logic [31:0] data, logic sup);
    idle(); cr_wr_en = 1; cr_code = code; cr_wdata = data; cr_super = sup;
    cyc(); idle();
  endtask

  task automatic rd(logic [11:0] code);
    idle(); dbg_rd_en = 1; dbg_code = code; cyc(); idle(); cyc();
  endtask

  task automatic req(logic [31:0] a, logic w, logic sup);
    idle(); req_valid = 1; req_addr = a; req_write = w; req_super = sup;
    cyc(); idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL [watchdog] run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state and defaults
    scen = "R1";
    @(negedge clk);
    repeat (3) cyc();
    rst = 0;
    cyc();
    rd(12'h004); rd(12'h005);
    dflt_cmode = 2'b10; dflt_bwe = 1;
    req(32'h4000_0000, 0, 1); cyc();

    // R2: descriptor loads with unimplemented bits cleared; other codes ignored
    scen = "R2";
    wr(12'h004, 32'h400F_FFFB, 1);   // base 0x40 mask 0x0F en mode 11 cmode 3 bwe 1 wp 0
    rd(12'h004);
    wr(12'h006, 32'hFFFF_FFFF, 1);
    wr(12'h003, 32'hFFFF_FFFF, 1);
    rd(12'h004); rd(12'h005);

    // R3: user-mode write rejected
    scen = "R3";
    wr(12'h005, 32'h8000_E004, 0);
    cyc();
    rd(12'h005);

    // R4: debug read of unrelated codes
    scen = "R4";
    rd(12'h000); rd(12'h006); rd(12'h104);

    // R5: flash and SRAM bypass, edges of windows
    scen = "R5";
    req(32'hF000_1234, 1, 1); req(32'hF007_FFFF, 0, 0);
    req(32'hF008_0000, 1, 1); req(32'h2000_8000, 1, 0);
    req(32'h2001_0000, 0, 1); req(32'h1FFF_FFFF, 0, 1);
    cyc();

    // R6: mask don't-care bits
    scen = "R6";
    req(32'h4A00_0000, 0, 0); req(32'h4F12_3456, 1, 1);
    req(32'h5000_0000, 0, 0); req(32'hC000_0000, 0, 1);

    // R7: privilege filter
    scen = "R7";
    wr(12'h005, 32'h8000_8044, 1);   // base 0x80, user only, cmode 2, wp
    req(32'h8000_0000, 0, 0); req(32'h8000_0000, 0, 1);
    wr(12'h005, 32'h8000_A020, 1);   // supervisor only, cmode 1
    req(32'h8000_0000, 0, 0); req(32'h8000_0000, 0, 1);
    wr(12'h005, 32'h8000_2020, 1);   // enable cleared: never matches
    req(32'h8000_0000, 0, 1);

    // R8: overlap, descriptor 0 wins
    scen = "R8";
    wr(12'h005, 32'h40FF_E034, 1);   // matches everything, wp set
    req(32'h4300_0000, 1, 1); req(32'h9900_0000, 1, 0);

    // R9: defaults on a miss
    scen = "R9";
    wr(12'h005, 32'h0000_0000, 1);
    dflt_cmode = 2'b01; dflt_bwe = 0;
    req(32'h9900_0000, 1, 1);
    dflt_cmode = 2'b11; dflt_bwe = 1;
    req(32'h0000_0100, 0, 0);

    // R10: write protect
    scen = "R10";
    wr(12'h004, 32'h4000_C004, 1);   // base 0x40, any mode, wp
    req(32'h4000_0010, 1, 1); req(32'h4000_0010, 0, 1); req(32'h4100_0000, 1, 1);

    // R11: back-to-back requests and idle gaps
    scen = "R11";
    idle(); req_valid = 1; req_addr = 32'h4000_0000; req_write = 1; req_super = 0; cyc();
    req_addr = 32'h2000_0004; cyc();
    req_addr = 32'h7700_0000; req_write = 0; cyc();
    idle(); cyc(); cyc();

    // mixed random traffic against the model
    scen = "RND";
    for (int n = 0; n < 400; n++) begin
      logic [7:0] tops [7];
      tops = '{8'h40, 8'h43, 8'h80, 8'h4A, 8'hF0, 8'h20, 8'h11};
      cr_wr_en  = ($urandom_range(0, 5) == 0);
      cr_code   = 12'(3 + $urandom_range(0, 3));
      cr_super  = ($urandom_range(0, 3) != 0);
      cr_wdata  = {tops[$urandom_range(0, 6)], 8'($urandom_range(0, 255)) & 8'h13,
                   16'($urandom)} | 32'h0000_8000;
      dbg_rd_en = ($urandom_range(0, 3) == 0);
      dbg_code  = 12'(3 + $urandom_range(0, 3));
      req_valid = ($urandom_range(0, 3) != 0);
      req_addr  = {tops[$urandom_range(0, 6)], 24'($urandom) & 24'h0F_FFFF};
      req_write = $urandom_range(0, 1) == 1;
      req_super = $urandom_range(0, 1) == 1;
      dflt_cmode = 2'($urandom_range(0, 3));
      dflt_bwe   = $urandom_range(0, 1) == 1;
      cyc();
    end
    idle(); cyc();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule